// File: doc/BRIEF.md
# GPIO Pad Configuration Register Bank

This block holds the per-pin configuration of a row of general-purpose pads and drives the pad-side control lines from it. Each pin owns two 32-bit registers on a simple memory-mapped bus. The control word chooses one of eight functions for the pin, a drive strength from 2 mA to 16 mA, a bias mode, and the pin direction. The I/O word holds the level the pin drives. It also reports the pad level after that level has passed through a two-flop synchronizer.

Pin `p` has its control word at `p * 2^STRIDE_LG + 0x0` and its I/O word at `p * 2^STRIDE_LG + 0x4`. A separate power-hold register sits at `HOLD_ADDR` (default 0x820), and it takes priority over any pin slot that shares its address. Writing zero to that register drops the `pwr_hold` output, which asks the system to reset. Bus reads are registered. The data appears on `bus_rdata` after the edge that accepts the read, and it holds until the next read. `NUM_PINS` may be set anywhere from 1 to 300, and `ADDR_W` must cover the highest pin slot.

Top module: `gpio_pad_bank`

## Requirements
- R1: After a synchronous reset, every pin shows function 0, drive code 0, bias 0, direction input and output level 0. `pwr_hold` is 1 and `bus_rdata` is 0.
- R2: Control-word bits [2:0] hold the function select of the pin, which appears on `pad_func[3p+2:3p]`. Code 0 is plain GPIO.
- R3: Control-word bits [6:4] hold the drive code v, which appears on `pad_drive[3p+2:3p]`. The code means (v+1)*2 mA, so codes 0 to 7 cover 2 to 16 mA.
- R4: Control-word bits [9:8] hold the bias code, which appears on `pad_pull[2p+1:2p]`. The codes are: 0 none, 1 pull-down, 2 keeper, 3 pull-up.
- R5: Control-word bit 12 is the output enable and appears on `pad_oe[p]`. A value of 1 means the pad drives and 0 means input only.
- R6: I/O-word bit 0 is the driven level, is read/write, and appears on `pad_out[p]`. I/O-word bit 1 is the input level and is read-only, so writing it has no effect.
- R7: A change on `pad_in[p]` before clock edge k shows in I/O-word bit 1 only for reads accepted at edge k+2 or later.
- R8: A write changes only the register it addresses. Writes to offsets other than +0x0 and +0x4, or to pin slots at or beyond `NUM_PINS`, change nothing, and reads of them return 0.
- R9: A read accepted at an edge puts the packed word on `bus_rdata` from that edge onward, with every undefined bit 0. Cycles without a read leave `bus_rdata` unchanged.
- R10: The power-hold register at `HOLD_ADDR` stores bit 0 and drives `pwr_hold`. Writing 0 drops `pwr_hold` and writing 1 raises it again. A read returns the stored bit in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NUM_PINS | Asynchronous pad levels |
| pad_out | output | NUM_PINS | Driven level per pin |
| pad_oe | output | NUM_PINS | Output enable per pin |
| pad_pull | output | 2*NUM_PINS | Bias code per pin |
| pad_drive | output | 3*NUM_PINS | Drive code per pin |
| pad_func | output | 3*NUM_PINS | Function select per pin |
| pwr_hold | output | 1 | Power-hold level, 0 requests reset |

## Verification
Two things can land in the same cycle: a bus access to a pin's I/O word, and a change of that pin's pad level moving through the synchronizer. The bench provokes this in two ways. It toggles `pad_in` in the same cycle as back-to-back reads and writes of the I/O word. It also applies random bus traffic while the pad levels change at random. A behavioural model is stepped at every edge. It computes the read result from the state before the edge, then applies the write, then shifts its synchronizer stages. Every pad output, `bus_rdata` and `pwr_hold` is compared with this model on every cycle. The read-only bit must follow the pad with exactly two cycles of delay, no matter what was written to it.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;

    localparam int WORD_W    = 32;
    localparam int FUNC_W    = 3;
    localparam int DRV_W     = 3;
    localparam int BIAS_W    = 2;
    localparam int PIN_IDX_W = 9;
    localparam int MAX_PINS  = 300;

    // control word field positions
    localparam int CTL_FUNC_LSB = 0;
    localparam int CTL_DRV_LSB  = 4;
    localparam int CTL_BIAS_LSB = 8;
    localparam int CTL_OE_BIT   = 12;

    // I/O word and power-hold word bit positions
    localparam int IO_OUT_BIT = 0;
    localparam int IO_IN_BIT  = 1;
    localparam int HOLD_BIT   = 0;

    localparam logic [WORD_W-1:0] CTL_MASK  = 32'h0000_1377;
    localparam logic [WORD_W-1:0] IO_MASK   = 32'h0000_0003;
    localparam logic [WORD_W-1:0] HOLD_MASK = 32'h0000_0001;
    localparam logic [WORD_W-1:0] RD_MASK   = CTL_MASK | IO_MASK | HOLD_MASK;

    typedef enum logic [BIAS_W-1:0] {
        BIAS_NONE = 2'd0,
        BIAS_DOWN = 2'd1,
        BIAS_KEEP = 2'd2,
        BIAS_UP   = 2'd3
    } bias_e;

    typedef struct packed {
        logic              oe;
        bias_e             bias;
        logic [DRV_W-1:0]  drive;
        logic [FUNC_W-1:0] func;
    } pin_ctl_t;

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_CTL  = 2'd1,
        RK_IO   = 2'd2,
        RK_HOLD = 2'd3
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e             kind;
        logic [PIN_IDX_W-1:0]  pin;
    } dec_t;

    function automatic logic [WORD_W-1:0] pack_ctl(pin_ctl_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[CTL_FUNC_LSB +: FUNC_W] = c.func;
        w[CTL_DRV_LSB  +: DRV_W]  = c.drive;
        w[CTL_BIAS_LSB +: BIAS_W] = c.bias;
        w[CTL_OE_BIT]             = c.oe;
        return w;
    endfunction

    function automatic pin_ctl_t unpack_ctl(logic [WORD_W-1:0] w);
        pin_ctl_t c;
        c.func  = w[CTL_FUNC_LSB +: FUNC_W];
        c.drive = w[CTL_DRV_LSB  +: DRV_W];
        c.bias  = bias_e'(w[CTL_BIAS_LSB +: BIAS_W]);
        c.oe    = w[CTL_OE_BIT];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_io(logic out_lvl, logic in_lvl);
        logic [WORD_W-1:0] w;
        w = '0;
        w[IO_OUT_BIT] = out_lvl;
        w[IO_IN_BIT]  = in_lvl;
        return w;
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_pad_pkg::*;
#(
    parameter int              NUM_PINS  = 16,
    parameter int              ADDR_W    = 13,
    parameter int              STRIDE_LG = 4,
    parameter int              CTL_OFF   = 0,
    parameter int              IO_OFF    = 4,
    parameter logic [ADDR_W-1:0] HOLD_ADDR = 13'h820
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam int IDX_W = ADDR_W - STRIDE_LG;

    logic [IDX_W-1:0]     idx;
    logic [STRIDE_LG-1:0] off;

    assign idx = addr[ADDR_W-1:STRIDE_LG];
    assign off = addr[STRIDE_LG-1:0];

    always_comb begin
        dec.kind = RK_NONE;
        dec.pin  = '0;
        if (addr == HOLD_ADDR) begin
            dec.kind = RK_HOLD;
        end else if (32'(idx) < NUM_PINS) begin
            dec.pin = PIN_IDX_W'(idx);
            if (off == STRIDE_LG'(CTL_OFF)) begin
                dec.kind = RK_CTL;
            end else if (off == STRIDE_LG'(IO_OFF)) begin
                dec.kind = RK_IO;
            end
        end
    end
endmodule

// File: rtl/gpio_pin_regs.sv
module gpio_pin_regs
    import gpio_pad_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ctl_we,
    input  logic     io_we,
    input  pin_ctl_t ctl_wval,
    input  logic     out_wval,
    input  logic     pad_in,
    output pin_ctl_t ctl_q,
    output logic     out_q,
    output logic     in_q
);
    logic meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= pin_ctl_t'('0);
            out_q  <= 1'b0;
            meta_q <= 1'b0;
            in_q   <= 1'b0;
        end else begin
            if (ctl_we) ctl_q <= ctl_wval;
            if (io_we)  out_q <= out_wval;
            meta_q <= pad_in;
            in_q   <= meta_q;
        end
    end

    AST_CTL_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
        !ctl_we |=> $stable(ctl_q)); // R8

    AST_OUT_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
        !io_we |=> $stable(out_q)); // R6
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
    import gpio_pad_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  dec_t                     dec,
    input  pin_ctl_t [NUM_PINS-1:0]  ctl_all,
    input  logic [NUM_PINS-1:0]      out_all,
    input  logic [NUM_PINS-1:0]      in_all,
    input  logic                     hold,
    output logic [WORD_W-1:0]        word
);
    localparam int SEL_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    logic [SEL_W-1:0] sel;
    logic             unused_pin_bits;

    assign sel             = dec.pin[SEL_W-1:0];
    assign unused_pin_bits = ^dec.pin;

    always_comb begin
        case (dec.kind)
            RK_CTL:  word = pack_ctl(ctl_all[sel]);
            RK_IO:   word = pack_io(out_all[sel], in_all[sel]);
            RK_HOLD: word = {{(WORD_W-1){1'b0}}, hold};
            default: word = '0;
        endcase
    end
endmodule

// File: rtl/gpio_pad_bank.sv
module gpio_pad_bank
    import gpio_pad_pkg::*;
#(
    parameter int                NUM_PINS  = 16,
    parameter int                ADDR_W    = 13,
    parameter int                STRIDE_LG = 4,
    parameter int                CTL_OFF   = 0,
    parameter int                IO_OFF    = 4,
    parameter logic [ADDR_W-1:0] HOLD_ADDR = 13'h820
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [WORD_W-1:0]          bus_wdata,
    output logic [WORD_W-1:0]          bus_rdata,
    input  logic [NUM_PINS-1:0]        pad_in,
    output logic [NUM_PINS-1:0]        pad_out,
    output logic [NUM_PINS-1:0]        pad_oe,
    output logic [BIAS_W*NUM_PINS-1:0] pad_pull,
    output logic [DRV_W*NUM_PINS-1:0]  pad_drive,
    output logic [FUNC_W*NUM_PINS-1:0] pad_func,
    output logic                       pwr_hold
);
    dec_t                    dec;
    pin_ctl_t                ctl_wval;
    pin_ctl_t [NUM_PINS-1:0] ctl_all;
    logic [NUM_PINS-1:0]     out_all;
    logic [NUM_PINS-1:0]     in_all;
    logic [NUM_PINS-1:0]     ctl_we_v;
    logic [NUM_PINS-1:0]     io_we_v;
    logic [WORD_W-1:0]       rd_word;
    logic                    hold_q;
    logic                    bus_write;
    logic                    bus_read;
    logic [1:0]              since_rst;
    logic                    unused_wdata_bits;

    assign bus_write = bus_sel && bus_wr;
    assign bus_read  = bus_sel && !bus_wr;
    assign ctl_wval  = unpack_ctl(bus_wdata);
    assign unused_wdata_bits = ^(bus_wdata & ~(CTL_MASK | IO_MASK));

    gpio_addr_decode #(
        .NUM_PINS (NUM_PINS),
        .ADDR_W   (ADDR_W),
        .STRIDE_LG(STRIDE_LG),
        .CTL_OFF  (CTL_OFF),
        .IO_OFF   (IO_OFF),
        .HOLD_ADDR(HOLD_ADDR)
    ) u_dec (
        .addr(bus_addr),
        .dec (dec)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        assign ctl_we_v[g] = bus_write && (dec.kind == RK_CTL)
                             && (dec.pin == PIN_IDX_W'(g));
        assign io_we_v[g]  = bus_write && (dec.kind == RK_IO)
                             && (dec.pin == PIN_IDX_W'(g));

        gpio_pin_regs u_pin (
            .clk     (clk),
            .rst     (rst),
            .ctl_we  (ctl_we_v[g]),
            .io_we   (io_we_v[g]),
            .ctl_wval(ctl_wval),
            .out_wval(bus_wdata[IO_OUT_BIT]),
            .pad_in  (pad_in[g]),
            .ctl_q   (ctl_all[g]),
            .out_q   (out_all[g]),
            .in_q    (in_all[g])
        );

        assign pad_func[g*FUNC_W +: FUNC_W]  = ctl_all[g].func;
        assign pad_drive[g*DRV_W +: DRV_W]   = ctl_all[g].drive;
        assign pad_pull[g*BIAS_W +: BIAS_W]  = ctl_all[g].bias;
        assign pad_oe[g]                     = ctl_all[g].oe;
        assign pad_out[g]                    = out_all[g];
    end

    gpio_rd_mux #(
        .NUM_PINS(NUM_PINS)
    ) u_rd (
        .dec    (dec),
        .ctl_all(ctl_all),
        .out_all(out_all),
        .in_all (in_all),
        .hold   (hold_q),
        .word   (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q    <= 1'b1;
            bus_rdata <= '0;
            since_rst <= 2'd0;
        end else begin
            if (bus_write && dec.kind == RK_HOLD) hold_q <= bus_wdata[HOLD_BIT];
            if (bus_read) bus_rdata <= rd_word;
            if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
        end
    end

    assign pwr_hold = hold_q;

    AST_HOLD_DROP: assert property (@(posedge clk) disable iff (rst)
        (bus_write && bus_addr == HOLD_ADDR && !bus_wdata[HOLD_BIT]) |=> !pwr_hold); // R10

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !(bus_write && bus_addr == HOLD_ADDR) |=> $stable(pwr_hold)); // R10

    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (rst)
        !bus_read |=> $stable(bus_rdata)); // R9

    AST_RDATA_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata & ~RD_MASK) == '0); // R9

    AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (in_all == $past(pad_in, 2))); // R7

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl_we_v, io_we_v})); // R8
endmodule

// File: tb/gpio_pad_bank_tb.sv
module gpio_pad_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP         = 6;
    localparam int AW         = 13;
    localparam logic [AW-1:0] HOLD_A = 13'h820;

    logic          clk = 1'b0;
    logic          rst;
    logic          bus_sel;
    logic          bus_wr;
    logic [AW-1:0] bus_addr;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic [2*NP-1:0] pad_pull;
    logic [3*NP-1:0] pad_drive;
    logic [3*NP-1:0] pad_func;
    logic          pwr_hold;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    // behavioural reference state
    int m_func[NP], m_drv[NP], m_bias[NP], m_oe[NP], m_out[NP], m_meta[NP], m_in[NP];
    int m_hold;
    logic [31:0] m_rdata;

    gpio_pad_bank #(.NUM_PINS(NP), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull(pad_pull),
        .pad_drive(pad_drive), .pad_func(pad_func), .pwr_hold(pwr_hold)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(logic [AW-1:0] a);
        int pin, off;
        if (a == HOLD_A) return 32'(m_hold);
        pin = int'(a) >> 4;
        off = int'(a) & 15;
        if (pin >= NP) return 32'h0;
        if (off == 0) return 32'(m_func[pin] | (m_drv[pin] << 4) | (m_bias[pin] << 8) | (m_oe[pin] << 12));
        if (off == 4) return 32'(m_out[pin] | (m_in[pin] << 1));
        return 32'h0;
    endfunction

    task automatic model_edge();
        int pin, off;
        if (rst) begin
            for (int p = 0; p < NP; p++) begin
                m_func[p] = 0; m_drv[p] = 0; m_bias[p] = 0; m_oe[p] = 0;
                m_out[p] = 0; m_meta[p] = 0; m_in[p] = 0;
            end
            m_hold = 1; m_rdata = '0;
            return;
        end
        if (bus_sel && !bus_wr) m_rdata = model_read(bus_addr);
        if (bus_sel && bus_wr) begin
            pin = int'(bus_addr) >> 4;
            off = int'(bus_addr) & 15;
            if (bus_addr == HOLD_A) m_hold = int'(bus_wdata[0]);
            else if (pin < NP && off == 0) begin
                m_func[pin] = int'(bus_wdata[2:0]);
                m_drv[pin]  = int'(bus_wdata[6:4]);
                m_bias[pin] = int'(bus_wdata[9:8]);
                m_oe[pin]   = int'(bus_wdata[12]);
            end else if (pin < NP && off == 4) m_out[pin] = int'(bus_wdata[0]);
        end
        for (int p = 0; p < NP; p++) begin
            m_in[p]   = m_meta[p];
            m_meta[p] = int'(pad_in[p]);
        end
    endtask

    task automatic compare_all();
        logic [3*NP-1:0] ef, ed;
        logic [2*NP-1:0] eb;
        logic [NP-1:0]   eo, ev;
        for (int p = 0; p < NP; p++) begin
            ef[3*p +: 3] = 3'(m_func[p]);
            ed[3*p +: 3] = 3'(m_drv[p]);
            eb[2*p +: 2] = 2'(m_bias[p]);
            eo[p] = m_oe[p][0];
            ev[p] = m_out[p][0];
        end
        check(pad_func == ef,  "R2", "pad_func",  64'(pad_func),  64'(ef));
        check(pad_drive == ed, "R3", "pad_drive", 64'(pad_drive), 64'(ed));
        check(pad_pull == eb,  "R4", "pad_pull",  64'(pad_pull),  64'(eb));
        check(pad_oe == eo,    "R5", "pad_oe",    64'(pad_oe),    64'(eo));
        check(pad_out == ev,   "R6", "pad_out",   64'(pad_out),   64'(ev));
        check(bus_rdata == m_rdata, "R9", "bus_rdata", 64'(bus_rdata), 64'(m_rdata));
        check(pwr_hold == m_hold[0], "R10", "pwr_hold", 64'(pwr_hold), 64'(m_hold));
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        #1;
        compare_all();
        @(negedge clk);
    endtask

    task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [AW-1:0] a);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        tick();
        bus_sel = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        check(pad_func == '0 && pad_drive == '0 && pad_pull == '0 && pad_oe == '0 && pad_out == '0,
              "R1", "pad fields", 64'({pad_func, pad_oe}), 64'(0));
        check(pwr_hold == 1'b1 && bus_rdata == 32'h0, "R1", "hold/rdata",
              64'({pwr_hold, bus_rdata}), 64'({1'b1, 32'h0}));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++; fails++;
            $display("FAIL R1 watchdog act=hung exp=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
        @(negedge clk);
        do_reset();

        // R2 R3 R4 R5: full control word on pin 2
        bus_write(13'h020, 32'h0000_1235);
        check(pad_func[8:6] == 3'd5, "R2", "pin2 func", 64'(pad_func[8:6]), 64'd5);
        check((int'(pad_drive[8:6]) + 1) * 2 == 8, "R3", "pin2 mA", 64'((int'(pad_drive[8:6]) + 1) * 2), 64'd8);
        check(pad_pull[5:4] == 2'd2, "R4", "pin2 keeper", 64'(pad_pull[5:4]), 64'd2);
        check(pad_oe[2] == 1'b1, "R5", "pin2 oe", 64'(pad_oe[2]), 64'd1);
        check(pad_func[5:3] == 3'd0 && pad_func[11:9] == 3'd0, "R8", "neighbours untouched",
              64'({pad_func[11:9], pad_func[5:3]}), 64'd0);

        // R4: every bias code on pin 0, R3: drive code 7 is 16 mA
        for (int b = 0; b < 4; b++) begin
            bus_write(13'h000, 32'(b << 8) | 32'h70);
            check(pad_pull[1:0] == 2'(b), "R4", "bias code", 64'(pad_pull[1:0]), 64'(b));
        end
        check((int'(pad_drive[2:0]) + 1) * 2 == 16, "R3", "max mA", 64'((int'(pad_drive[2:0]) + 1) * 2), 64'd16);
        bus_read(13'h000);
        check(bus_rdata == 32'h0000_0370, "R9", "ctl readback", 64'(bus_rdata), 64'h370);

        // R6: output bit writes, input bit write ignored
        bus_write(13'h014, 32'hFFFF_FFFF);
        check(pad_out[1] == 1'b1, "R6", "pin1 out", 64'(pad_out[1]), 64'd1);
        bus_read(13'h014);
        check(bus_rdata == 32'h1, "R6", "in bit not writable", 64'(bus_rdata), 64'h1);

        // R7: pad change concurrent with I/O accesses
        pad_in[3] = 1'b1;
        bus_read(13'h034);
        check(bus_rdata[1] == 1'b0, "R7", "edge k read", 64'(bus_rdata[1]), 64'd0);
        pad_in[3] = 1'b1;
        bus_write(13'h034, 32'h2);
        bus_read(13'h034);
        check(bus_rdata[1] == 1'b1, "R7", "edge k+2 read", 64'(bus_rdata[1]), 64'd1);
        check(bus_rdata[0] == 1'b0, "R6", "out kept 0", 64'(bus_rdata[0]), 64'd0);

        // R8: unmapped slot and offset
        bus_write(13'(NP * 16), 32'h1777);
        bus_write(13'h028, 32'h1777);
        bus_read(13'h028);
        check(bus_rdata == 32'h0, "R8", "unmapped offset read", 64'(bus_rdata), 64'h0);
        bus_read(13'(NP * 16));
        check(bus_rdata == 32'h0, "R8", "unmapped pin read", 64'(bus_rdata), 64'h0);

        // R10: power hold
        bus_read(HOLD_A);
        check(bus_rdata == 32'h1, "R10", "hold read", 64'(bus_rdata), 64'h1);
        bus_write(HOLD_A, 32'hFFFF_FFFE);
        check(pwr_hold == 1'b0, "R10", "hold dropped", 64'(pwr_hold), 64'd0);
        bus_write(HOLD_A, 32'h1);
        check(pwr_hold == 1'b1, "R10", "hold raised", 64'(pwr_hold), 64'd1);

        // random traffic with pad activity in the same cycles
        for (int i = 0; i < 400; i++) begin
            int r, pin, off;
            r = int'($urandom);
            pin = (r & 32'h7fff) % (NP + 1);
            off = ((r >> 16) % 3) * 4;
            pad_in = NP'($urandom);
            bus_sel = r[20];
            bus_wr = r[21];
            bus_addr = (r[25:22] == 4'd0) ? HOLD_A : 13'(pin * 16 + off);
            bus_wdata = $urandom;
            tick();
        end
        bus_sel = 1'b0;

        do_reset();
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule